// File: doc/BRIEF.md
# Bidirectional Storing Bus Transceiver

This block connects two parallel buses, side A and side B, with one storage path in each direction. Each path has its own latch-enable, capture strobe and output enable. The path can follow its input, keep what it already holds, or take a snapshot of its input when the strobe makes a low-to-high transition. Everything runs on one system clock with a synchronous active-high reset. The strobe is a sampled data input, and its rising transition is found by comparing it with its value one clock earlier. The stored value and the output enables are registered, so every effect shows up on the outputs one clock after the inputs that cause it.

Each bus is split into an input word, a per-bit "externally driven" flag, an output word and an output-enable flag. A bus-hold stage on each input keeps the last level that was driven on every bit. When the external driver releases a bit, the path sees that remembered level in place of a floating value. The B outputs are enabled by an active-high control. The A outputs are enabled by an active-low control.

Top module: `bidir_store_xcvr`

## Requirements
- R1: While reset is asserted, and on the first clock after it, both output words are zero and both output-enable flags are 0.
- R2: When a path's latch-enable is 1 at a clock edge, that path's output word equals its effective input one clock later (transparent mode).
- R3: When a path's latch-enable is 0 and its strobe shows no low-to-high transition, the path's output word does not change. This holds whether the strobe stays high or stays low.
- R4: When the latch-enable is 0 and the strobe is 1 at a clock edge after being 0 at the previous edge, the path stores its effective input, and the output shows it one clock later. A strobe that stays high, or that falls, stores nothing.
- R5: When the latch-enable goes from 1 to 0, the path keeps the input value sampled at the last edge where the enable was 1.
- R6: The B-side output-enable flag equals the A-to-B enable control (active high) from the previous clock.
- R7: The A-side output-enable flag equals the inverse of the B-to-A enable control (active low) from the previous clock.
- R8: For each bit whose drive flag is 0, the effective input is the last level that was driven on that bit (0 if it has never been driven since reset). Bits whose drive flag is 1 pass the bus value.
- R9: The two directions are independent: activity on one path's controls and data leaves the other path's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | A-bus value seen at the pins |
| a_drv | input | WIDTH | Per bit: 1 when an external agent drives the A bit |
| a_out | output | WIDTH | Word driven onto the A bus (B-to-A path) |
| a_oe | output | 1 | A-side output enable |
| b_in | input | WIDTH | B-bus value seen at the pins |
| b_drv | input | WIDTH | Per bit: 1 when an external agent drives the B bit |
| b_out | output | WIDTH | Word driven onto the B bus (A-to-B path) |
| b_oe | output | 1 | B-side output enable |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch-enable |
| ab_strobe | input | 1 | A-to-B capture strobe |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch-enable |
| ba_strobe | input | 1 | B-to-A capture strobe |

## Verification
The case that is hardest to reach from the ports is a word made partly of live bus bits and partly of remembered levels. The remembered levels are internal, so they can only be seen through a transparent path. The stimulus first drives a known word with all bits driven. It then releases every bit and shows, through the transparent path, that the word survives while the pins carry garbage. It then drives only the low half with a new pattern, so the output must combine fresh low bits with remembered high bits. Capture is exercised with the strobe held high and then falling while the data changes, so that storing on a level or on the wrong edge would show up.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    PATH_KEEP    = 2'd0,
    PATH_PASS    = 2'd1,
    PATH_CAPTURE = 2'd2
  } path_mode_e;

endpackage

// File: rtl/xcvr_bus_hold.sv
module xcvr_bus_hold #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin,
  input  logic [WIDTH-1:0] drv,
  output logic [WIDTH-1:0] eff
);

  logic [WIDTH-1:0] keep_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         keep_q[i] <= 1'b0;
      else if (drv[i]) keep_q[i] <= pin[i];
    end
    assign eff[i] = drv[i] ? pin[i] : keep_q[i];
  end

  // R8: an undriven bit keeps the level it had one clock earlier
  a_r8_released_bits_stay: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((eff ^ $past(eff)) & ~drv) == '0));

endmodule

// File: rtl/xcvr_edge_detect.sv
module xcvr_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);

  logic prev_q;

  // Reset to 1: a strobe held high through reset is not taken as an edge.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;

endmodule

// File: rtl/xcvr_path_store.sv
module xcvr_path_store
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic             le,
  input  logic             rise,
  output logic [WIDTH-1:0] dout
);

  path_mode_e       mode;
  logic [WIDTH-1:0] store_q;

  always_comb begin
    if (le)        mode = PATH_PASS;
    else if (rise) mode = PATH_CAPTURE;
    else           mode = PATH_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else begin
      case (mode)
        PATH_PASS, PATH_CAPTURE: store_q <= din;
        default:                 store_q <= store_q;
      endcase
    end
  end

  assign dout = store_q;

  // R2: transparent mode follows the input one clock later
  a_r2_pass_follows: assert property (@(posedge clk) disable iff (rst)
    le |=> dout == $past(din));

  // R3: no latch-enable and no rising strobe keeps the output
  a_r3_keep_stable: assert property (@(posedge clk) disable iff (rst)
    (!le && !rise) |=> $stable(dout));

  // R4: a rising strobe stores the input
  a_r4_edge_capture: assert property (@(posedge clk) disable iff (rst)
    (!le && rise) |=> dout == $past(din));

endmodule

// File: rtl/xcvr_direction.sv
module xcvr_direction #(
  parameter int WIDTH         = 18,
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] src_pin,
  input  logic [WIDTH-1:0] src_drv,
  input  logic             oe_ctl,
  input  logic             le,
  input  logic             strobe,
  output logic [WIDTH-1:0] dst_out,
  output logic             dst_oe
);

  logic [WIDTH-1:0] src_eff;
  logic             rise;
  logic             oe_on;
  logic             oe_q;

  xcvr_bus_hold #(.WIDTH(WIDTH)) u_hold (
    .clk (clk),
    .rst (rst),
    .pin (src_pin),
    .drv (src_drv),
    .eff (src_eff)
  );

  xcvr_edge_detect u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (strobe),
    .rise  (rise)
  );

  xcvr_path_store #(.WIDTH(WIDTH)) u_store (
    .clk  (clk),
    .rst  (rst),
    .din  (src_eff),
    .le   (le),
    .rise (rise),
    .dout (dst_out)
  );

  if (OE_ACTIVE_LOW) begin : g_oe_low
    assign oe_on = ~oe_ctl;
  end else begin : g_oe_high
    assign oe_on = oe_ctl;
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= oe_on;
  end

  assign dst_oe = oe_q;

endmodule

// File: rtl/bidir_store_xcvr.sv
module bidir_store_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] a_drv,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] b_drv,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             ab_oe,
  input  logic             ab_le,
  input  logic             ab_strobe,
  input  logic             ba_oe_n,
  input  logic             ba_le,
  input  logic             ba_strobe
);

  xcvr_direction #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0)) u_a2b (
    .clk     (clk),
    .rst     (rst),
    .src_pin (a_in),
    .src_drv (a_drv),
    .oe_ctl  (ab_oe),
    .le      (ab_le),
    .strobe  (ab_strobe),
    .dst_out (b_out),
    .dst_oe  (b_oe)
  );

  xcvr_direction #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1)) u_b2a (
    .clk     (clk),
    .rst     (rst),
    .src_pin (b_in),
    .src_drv (b_drv),
    .oe_ctl  (ba_oe_n),
    .le      (ba_le),
    .strobe  (ba_strobe),
    .dst_out (a_out),
    .dst_oe  (a_oe)
  );

  // R1: reset clears both words and both enables
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  // R6: B-side enable is active high, one clock later
  a_r6_b_enable_on: assert property (@(posedge clk) disable iff (rst)
    ab_oe |=> b_oe);
  a_r6_b_enable_off: assert property (@(posedge clk) disable iff (rst)
    !ab_oe |=> !b_oe);

  // R7: A-side enable is active low, one clock later
  a_r7_a_enable_on: assert property (@(posedge clk) disable iff (rst)
    !ba_oe_n |=> a_oe);
  a_r7_a_enable_off: assert property (@(posedge clk) disable iff (rst)
    ba_oe_n |=> !a_oe);

endmodule

// File: tb/bidir_store_xcvr_test.sv
module bidir_store_xcvr_test;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, a_drv, a_out, b_in, b_drv, b_out;
  logic         a_oe, b_oe;
  logic         ab_oe, ab_le, ab_strobe, ba_oe_n, ba_le, ba_strobe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bidir_store_xcvr #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_strobe(ab_strobe),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_strobe(ba_strobe)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    a_in = '0; a_drv = '0; b_in = '0; b_drv = '0;
    ab_oe = 1'b0; ab_le = 1'b0; ab_strobe = 1'b0;
    ba_oe_n = 1'b1; ba_le = 1'b0; ba_strobe = 1'b0;
    repeat (3) step();
    check("R1 a_out", a_out, '0);
    check("R1 b_out", b_out, '0);
    check("R1 oe", {16'd0, a_oe, b_oe}, '0);
    rst = 1'b0;
    step();
    check("R1 after release", {16'd0, a_oe, b_oe}, '0);
  endtask

  task automatic t_transparent();
    a_drv = '1;
    ab_le = 1'b1; a_in = 18'h2A5C3;
    step();
    check("R2 first word", b_out, 18'h2A5C3);
    a_in = 18'h1F00E;
    step();
    check("R2 second word", b_out, 18'h1F00E);
  endtask

  task automatic t_le_fall();
    a_in = 18'h3C3C3;
    step();
    check("R5 last transparent", b_out, 18'h3C3C3);
    ab_le = 1'b0; a_in = 18'h00FFF;
    step();
    check("R5 value kept at fall", b_out, 18'h3C3C3);
  endtask

  task automatic t_hold_levels();
    ab_strobe = 1'b0; a_in = 18'h12345;
    step(); step();
    check("R3 strobe low", b_out, 18'h3C3C3);
    ab_strobe = 1'b1; a_in = 18'h0ABCD;
    step();
    check("R4 rising stores", b_out, 18'h0ABCD);
    a_in = 18'h2FFFF;
    step(); step();
    check("R3 strobe held high", b_out, 18'h0ABCD);
    ab_strobe = 1'b0; a_in = 18'h11111;
    step();
    check("R4 falling stores nothing", b_out, 18'h0ABCD);
    ab_strobe = 1'b1; a_in = 18'h22222;
    step();
    check("R4 second rising", b_out, 18'h22222);
    ab_strobe = 1'b0;
    step();
  endtask

  task automatic t_enables();
    ab_oe = 1'b1;
    step();
    check("R6 b_oe on", {17'd0, b_oe}, 18'd1);
    ab_oe = 1'b0;
    step();
    check("R6 b_oe off", {17'd0, b_oe}, 18'd0);
    ba_oe_n = 1'b0;
    step();
    check("R7 a_oe on with low control", {17'd0, a_oe}, 18'd1);
    ba_oe_n = 1'b1;
    step();
    check("R7 a_oe off with high control", {17'd0, a_oe}, 18'd0);
  endtask

  task automatic t_reverse_path();
    b_drv = '1;
    ba_le = 1'b1; b_in = 18'h35A5A;
    a_in = 18'h3FFFF;
    step();
    check("R2 B-to-A transparent", a_out, 18'h35A5A);
    check("R9 A-to-B untouched", b_out, 18'h22222);
    ba_le = 1'b0; b_in = 18'h01234;
    step();
    check("R5 B-to-A kept", a_out, 18'h35A5A);
    ba_strobe = 1'b1;
    step();
    check("R4 B-to-A capture", a_out, 18'h01234);
    ab_le = 1'b1; a_in = 18'h0F0F0;
    step();
    check("R9 B-to-A untouched", a_out, 18'h01234);
    ab_le = 1'b0; ba_strobe = 1'b0;
    step();
  endtask

  task automatic t_bus_hold();
    ab_le = 1'b1; a_drv = '1; a_in = 18'h2B6D9;
    step();
    check("R8 driven word", b_out, 18'h2B6D9);
    a_drv = '0; a_in = 18'h15555;
    step();
    check("R8 all released", b_out, 18'h2B6D9);
    a_drv = 18'h001FF; a_in = 18'h3C0A7;
    step();
    check("R8 low half driven", b_out, 18'h2B6D9 & 18'h3FE00 | 18'h3C0A7 & 18'h001FF);
    a_drv = '0; a_in = 18'h00000;
    step();
    check("R8 merged word retained", b_out, 18'h2B6D9 & 18'h3FE00 | 18'h3C0A7 & 18'h001FF);
    ab_le = 1'b0;
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_le_fall();
    t_hold_levels();
    t_enables();
    t_reverse_path();
    t_bus_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule